// File: doc/BRIEF.md
# Three-Register Point-to-Point Transfer Network

This block holds three registers of a parameterised width and lets any of them be rewritten from one of the other two on a clock edge. Each destination register has a private two-input selector. The selector's inputs are the two other registers. Each register also has its own write enable. Because no path is shared, up to three independent moves can take place at one edge. A swap, a three-way rotation or a fan-out of one register into the other two each finishes in a single cycle, and each uses the values the registers held before that edge.

A parallel initialisation port writes all three registers at once from external data. It is used to seed the bank before transfers begin. A synchronous reset clears the bank. Arithmetic, memory and any shared bus are outside this block.

Top module: `xfer_net_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three registers become zero at that edge. Reset overrides `init_we` and every `ld_en` bit.
- R2: When `init_we` is high and `rst` is low at an edge, `q0`, `q1` and `q2` take `init_d0`, `init_d1` and `init_d2`. This happens whatever `sel` and `ld_en` hold.
- R3: Register 0, with `ld_en[0]` high and no reset or initialisation, takes register 1 when `sel[0]`=0 and register 2 when `sel[0]`=1.
- R4: Register 1, with `ld_en[1]` high, takes register 0 when `sel[1]`=0 and register 2 when `sel[1]`=1.
- R5: Register 2, with `ld_en[2]` high, takes register 0 when `sel[2]`=0 and register 1 when `sel[2]`=1.
- R6: A register whose `ld_en` bit is low, with no reset or initialisation, keeps its value whatever its `sel` bit holds.
- R7: With `sel[2:1]`=2'b11 and `ld_en[2:1]`=2'b11, registers 1 and 2 exchange their old values in one edge.
- R8: Three transfers at one edge all use the pre-edge values. With `sel`=3'b101 and `ld_en`=3'b111 the bank rotates (2 from 1, 1 from 0, 0 from 2). With `sel`=3'b010 and `ld_en`=3'b111 it rotates the other way.
- R9: With `sel[2:1]`=2'b00 and `ld_en`=3'b110, registers 1 and 2 both take register 0, and register 0 is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| init_we | input | 1 | Parallel initialisation write for all three registers |
| init_d0 | input | W | Initialisation data for register 0 |
| init_d1 | input | W | Initialisation data for register 1 |
| init_d2 | input | W | Initialisation data for register 2 |
| sel | input | 3 | Per-register source select, bit k for register k |
| ld_en | input | 3 | Per-register transfer enable, bit k for register k |
| q0 | output | W | Register 0 value |
| q1 | output | W | Register 1 value |
| q2 | output | W | Register 2 value |

## Verification
Two of this block's functions can fall on the same edge. Initialisation can coincide with transfer enables, and reset can coincide with initialisation. The bench provokes both: it raises `init_we` with every `ld_en` bit set and a rotating select pattern, then raises `rst` together with `init_we`. Each case is judged by whether the outputs after that edge show only the winning source. That means the initialisation data in the first case and zeros in the second, with no trace of a transfer. Simultaneous transfers among the registers themselves (swap, both rotations, fan-out) are judged the same way, against values worked out from the old register contents.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int NREG = 3;

    // lower-numbered of the two registers other than k
    function automatic int lo_src(input int k);
        return (k == 0) ? 1 : 0;
    endfunction

    // higher-numbered of the two registers other than k
    function automatic int hi_src(input int k);
        return (k == NREG - 1) ? NREG - 2 : NREG - 1;
    endfunction
endpackage

// File: rtl/xfer_src_mux.sv
module xfer_src_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] hi_in,
    input  logic         pick_hi,
    output logic [W-1:0] y
);
    always_comb begin
        y = pick_hi ? hi_in : lo_in;
    end
endmodule

// File: rtl/xfer_reg_cell.sv
module xfer_reg_cell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_we,
    input  logic [W-1:0] init_d,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (init_we) begin
            q <= init_d;
        end else if (ld) begin
            q <= d;
        end
    end
endmodule

// File: rtl/xfer_net_top.sv
module xfer_net_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_we,
    input  logic [W-1:0] init_d0,
    input  logic [W-1:0] init_d1,
    input  logic [W-1:0] init_d2,
    input  logic [2:0]   sel,
    input  logic [2:0]   ld_en,
    output logic [W-1:0] q0,
    output logic [W-1:0] q1,
    output logic [W-1:0] q2
);
    import xfer_pkg::*;

    logic [W-1:0] bank   [NREG];
    logic [W-1:0] next_d [NREG];
    logic [W-1:0] seed   [NREG];

    always_comb begin
        seed[0] = init_d0;
        seed[1] = init_d1;
        seed[2] = init_d2;
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam int LO = lo_src(k);
        localparam int HI = hi_src(k);

        xfer_src_mux #(.W(W)) u_mux (
            .lo_in   (bank[LO]),
            .hi_in   (bank[HI]),
            .pick_hi (sel[k]),
            .y       (next_d[k])
        );

        xfer_reg_cell #(.W(W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .init_we (init_we),
            .init_d  (seed[k]),
            .ld      (ld_en[k]),
            .d       (next_d[k]),
            .q       (bank[k])
        );
    end

    assign q0 = bank[0];
    assign q1 = bank[1];
    assign q2 = bank[2];
endmodule

// File: rtl/xfer_net_chk.sv
module xfer_net_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         init_we,
    input logic [W-1:0] init_d0,
    input logic [W-1:0] init_d1,
    input logic [W-1:0] init_d2,
    input logic [2:0]   sel,
    input logic [2:0]   ld_en,
    input logic [W-1:0] q0,
    input logic [W-1:0] q1,
    input logic [W-1:0] q2
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (q0 == '0 && q1 == '0 && q2 == '0));

    // R2
    init_priority_chk: assert property (@(posedge clk) disable iff (rst)
        init_we |=> (q0 == $past(init_d0) && q1 == $past(init_d1) && q2 == $past(init_d2)));

    // R3
    r0_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_we && ld_en[0]) |=> (q0 == ($past(sel[0]) ? $past(q2) : $past(q1))));

    // R4
    r1_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_we && ld_en[1]) |=> (q1 == ($past(sel[1]) ? $past(q2) : $past(q0))));

    // R5
    r2_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_we && ld_en[2]) |=> (q2 == ($past(sel[2]) ? $past(q1) : $past(q0))));

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_we && ld_en == 3'b000) |=> ($stable(q0) && $stable(q1) && $stable(q2)));

    // R7
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_we && ld_en[2:1] == 2'b11 && sel[2:1] == 2'b11)
        |=> (q1 == $past(q2) && q2 == $past(q1)));

    // R9
    fanout_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_we && ld_en == 3'b110 && sel[2:1] == 2'b00)
        |=> (q1 == $past(q0) && q2 == $past(q0) && $stable(q0)));
endmodule

bind xfer_net_top xfer_net_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .init_we (init_we),
    .init_d0 (init_d0),
    .init_d1 (init_d1),
    .init_d2 (init_d2),
    .sel     (sel),
    .ld_en   (ld_en),
    .q0      (q0),
    .q1      (q1),
    .q2      (q2)
);

// File: tb/xfer_net_top_tb_top.sv
`timescale 1ns/1ps
module xfer_net_top_tb_top;
    localparam int W = 8;
    localparam int NV = 17;

    logic         clk = 1'b0;
    logic         rst;
    logic         init_we;
    logic [W-1:0] init_d0, init_d1, init_d2;
    logic [2:0]   sel, ld_en;
    logic [W-1:0] q0, q1, q2;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    xfer_net_top #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .init_we(init_we),
        .init_d0(init_d0), .init_d1(init_d1), .init_d2(init_d2),
        .sel(sel), .ld_en(ld_en), .q0(q0), .q1(q1), .q2(q2)
    );

    // row: {init, sel[2:0], ld_en[2:0], e0, e1, e2}; init rows drive the e values as seed data
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 3'b000, 3'b000, 8'h11, 8'h22, 8'h33},  // R2 seed
        {1'b0, 3'b110, 3'b110, 8'h11, 8'h33, 8'h22},  // R7 swap
        {1'b0, 3'b101, 3'b111, 8'h22, 8'h11, 8'h33},  // R8 rotate
        {1'b0, 3'b000, 3'b001, 8'h11, 8'h11, 8'h33},  // R3 from reg1
        {1'b0, 3'b001, 3'b001, 8'h33, 8'h11, 8'h33},  // R3 from reg2
        {1'b1, 3'b111, 3'b000, 8'h5A, 8'hA5, 8'h3C},  // R2 seed
        {1'b0, 3'b000, 3'b010, 8'h5A, 8'h5A, 8'h3C},  // R4 from reg0
        {1'b0, 3'b010, 3'b010, 8'h5A, 8'h3C, 8'h3C},  // R4 from reg2
        {1'b1, 3'b000, 3'b000, 8'h01, 8'h02, 8'h04},  // R2 seed
        {1'b0, 3'b000, 3'b100, 8'h01, 8'h02, 8'h01},  // R5 from reg0
        {1'b0, 3'b100, 3'b100, 8'h01, 8'h02, 8'h02},  // R5 from reg1
        {1'b0, 3'b111, 3'b000, 8'h01, 8'h02, 8'h02},  // R6 hold all
        {1'b1, 3'b000, 3'b000, 8'h0F, 8'hF0, 8'h81},  // R2 seed
        {1'b0, 3'b001, 3'b110, 8'h0F, 8'h0F, 8'h0F},  // R9 fan-out
        {1'b1, 3'b000, 3'b000, 8'hC0, 8'h03, 8'h99},  // R2 seed
        {1'b0, 3'b010, 3'b111, 8'h03, 8'h99, 8'hC0},  // R8 reverse rotate
        {1'b0, 3'b111, 3'b010, 8'h03, 8'hC0, 8'hC0}   // R6 partial hold
    };

    task automatic check(input string tag, input logic [3*W-1:0] exp);
        n_chk++;
        if ({q0, q1, q2} !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, {q0, q1, q2}, exp);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; init_we = 1'b0; sel = 3'b000; ld_en = 3'b000;
        init_d0 = '0; init_d1 = '0; init_d2 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 24'h000000);

        for (int i = 0; i < NV; i++) begin
            init_we = VEC[i][30];
            sel     = VEC[i][29:27];
            ld_en   = VEC[i][26:24];
            init_d0 = VEC[i][23:16];
            init_d1 = VEC[i][15:8];
            init_d2 = VEC[i][7:0];
            @(negedge clk);
            check($sformatf("table row %0d (R2..R9)", i), VEC[i][23:0]);
        end

        // R2: initialisation wins over a full set of transfer enables
        init_we = 1'b1; sel = 3'b101; ld_en = 3'b111;
        init_d0 = 8'hAA; init_d1 = 8'hBB; init_d2 = 8'hCC;
        @(negedge clk);
        check("R2 init over transfers", 24'hAABBCC);

        // R6: all enables low with changing selects after seed
        init_we = 1'b0; ld_en = 3'b000; sel = 3'b010;
        @(negedge clk);
        sel = 3'b101;
        @(negedge clk);
        check("R6 hold with select toggling", 24'hAABBCC);

        // R7: swap back to back returns original order
        sel = 3'b110; ld_en = 3'b110;
        @(negedge clk);
        check("R7 swap first", 24'hAACCBB);
        @(negedge clk);
        check("R7 swap second", 24'hAABBCC);

        // R1: reset beats initialisation and transfers
        rst = 1'b1; init_we = 1'b1; ld_en = 3'b111; sel = 3'b101;
        @(negedge clk);
        check("R1 reset over init", 24'h000000);
        rst = 1'b0; init_we = 1'b0; ld_en = 3'b000;
        @(negedge clk);
        check("R1 stays clear", 24'h000000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule